// File: doc/BRIEF.md
# SPI Register and FIFO Access Slave

This block is a serial peripheral slave that gives an external host read and write access to a byte-wide register space with 7-bit addresses and to a byte queue. The host selects the slave by pulling the active-low chip select. It then clocks one command byte followed by any number of data bytes. The command byte carries the direction in its top bit and the start address in the remaining seven bits. A single-byte access is simply a burst of length one, so one frame format covers every kind of access.

Address 0x00 is the queue port, and the address stays fixed there for the whole frame. Each data byte written there is pushed into the queue, and each data byte read there pops one entry. Any other address steps by one after every data byte and wraps from 0x7F back to 0x01. While the host writes a register, the byte it receives back is that register's content from before the write.

The serial pins are synchronized into the system clock, which must run at least 8 times the serial clock. The register file sits outside the block behind a plain address/write-enable port with a combinational read-data return. The queue also sits outside, behind two valid/ready streams. On the push side, `push_valid` is a one-cycle strobe raised only while `push_ready` is high. A byte that arrives while `push_ready` is low is dropped and never offered. On the pop side, `pop_data` must show the queue head whenever `pop_valid` is high. The block peeks at the head to serve the serial read and raises `pop_ready` for one cycle once that byte has been fully shifted out. A read that prefetches the next head therefore never consumes an entry the host did not clock.

Top module: `spi_reg_slave`

## Requirements
- R1: The first byte of a frame is a command: bit 7 set means write and bit 7 clear means read, and bits 6:0 give the start address, received MSB first. In a read frame, the data bytes arriving on MOSI change no register.
- R2: Data bytes travel MSB first, in SPI mode 0: MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. A read returns the addressed register's value.
- R3: For any address other than 0x00, the address advances by one after each data byte of the frame, and 0x7F is followed by 0x01.
- R4: Address 0x00 is the queue port and does not advance. Each write data byte there is pushed once, and each read data byte pops exactly one entry, in arrival order. No entry is lost between frames.
- R5: During a write data byte, MISO returns the target register's value from before that write. During a write to the queue port, MISO returns 0x00.
- R6: Raising the chip select ends the frame and discards a partly received byte. The next byte after a new select is always a command. MISO is 0 while deselected and during the command byte.
- R7: A read of the queue port while it is empty returns 0x00, issues no pop, and sets `fifo_udf`, which stays set until reset.
- R8: A queue write while `push_ready` is low is dropped without a push strobe and sets `fifo_ovf`, which stays set until reset.
- R9: After reset, MISO, both flags and all strobes (`reg_we`, `push_valid`, `pop_ready`) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select that frames a transfer |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 7 | Register file address (current frame address) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr`, combinational |
| push_valid | output | 1 | Queue push strobe |
| push_data | output | 8 | Byte to push |
| push_ready | input | 1 | Queue has room |
| pop_valid | input | 1 | Queue holds at least one entry |
| pop_data | input | 8 | Queue head |
| pop_ready | output | 1 | Queue pop strobe |
| fifo_ovf | output | 1 | Sticky overflow flag |
| fifo_udf | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, the full 7-bit address space, and the serial clock at 8 system clocks per half period. Against it, the bench places a 128-byte register model and a queue model only four entries deep. With this setup, every register address can be written one at a time and the whole space read back in a single 127-byte burst, and a short burst crosses the 0x7F-to-0x01 wrap for both reads and writes. The shallow queue puts overflow, drain-to-empty and underflow within a few frames. The same runs also cover an aborted partial byte and a frame-spanning pop order.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t FIFO_ADDR  = '0;
  localparam addr_t ADDR_LAST  = '1;
  localparam addr_t ADDR_FIRST = addr_t'(1);
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_s,
  input  logic  mosi_s,
  input  logic  sel_s,
  input  logic  load_en,
  input  byte_t load_byte,
  output logic  miso,
  output logic  byte_done,
  output logic  cmd_byte,
  output byte_t rx_byte
);
  logic             sck_q;
  logic [CNT_W-1:0] bit_cnt;
  byte_t            rx_sh, tx_sh;
  logic             cmd_ph;
  logic             rise, fall;

  assign rise = sck_s & ~sck_q;
  assign fall = ~sck_s & sck_q;
  assign miso = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      cmd_ph    <= 1'b1;
      byte_done <= 1'b0;
      cmd_byte  <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sck_q     <= sck_s;
      byte_done <= 1'b0;
      if (!sel_s) begin
        bit_cnt <= '0;
        cmd_ph  <= 1'b1;
        tx_sh   <= '0;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(DATA_W-1)) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh[DATA_W-2:0], mosi_s};
            cmd_byte  <= cmd_ph;
            cmd_ph    <= 1'b0;
          end
        end
        if (load_en)
          tx_sh <= load_byte;
        else if (fall && bit_cnt != '0)
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assert_idle_miso_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !miso);

  assert_byte_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
endmodule

// File: rtl/spi_access.sv
module spi_access
  import spi_reg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_s,
  input  logic  byte_done,
  input  logic  cmd_byte,
  input  byte_t rx_byte,
  output logic  load_en,
  output byte_t load_byte,
  output addr_t reg_addr,
  output logic  reg_we,
  output byte_t reg_wdata,
  input  byte_t reg_rdata,
  output logic  push_valid,
  output byte_t push_data,
  input  logic  push_ready,
  input  logic  pop_valid,
  input  byte_t pop_data,
  output logic  pop_ready,
  output logic  fifo_ovf,
  output logic  fifo_udf
);
  logic  wr_dir, load_pend, have_q;
  addr_t addr;
  logic  is_fifo, data_done;

  assign is_fifo   = (addr == FIFO_ADDR);
  assign data_done = byte_done & ~cmd_byte & sel_s;

  assign reg_addr   = addr;
  assign reg_wdata  = rx_byte;
  assign reg_we     = data_done & wr_dir & ~is_fifo;
  assign push_data  = rx_byte;
  assign push_valid = data_done & wr_dir & is_fifo & push_ready;
  assign pop_ready  = data_done & ~wr_dir & is_fifo & have_q;

  assign load_en = load_pend & sel_s;

  always_comb begin
    if (!is_fifo)     load_byte = reg_rdata;
    else if (wr_dir)  load_byte = '0;
    else if (pop_valid) load_byte = pop_data;
    else              load_byte = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_dir    <= 1'b0;
      addr      <= '0;
      load_pend <= 1'b0;
      have_q    <= 1'b0;
      fifo_ovf  <= 1'b0;
      fifo_udf  <= 1'b0;
    end else if (!sel_s) begin
      load_pend <= 1'b0;
      have_q    <= 1'b0;
    end else begin
      if (load_pend) begin
        load_pend <= 1'b0;
        have_q    <= is_fifo & ~wr_dir & pop_valid;
      end
      if (byte_done) begin
        load_pend <= 1'b1;
        if (cmd_byte) begin
          wr_dir <= rx_byte[DATA_W-1];
          addr   <= rx_byte[ADDR_W-1:0];
        end else if (!is_fifo) begin
          addr <= (addr == ADDR_LAST) ? ADDR_FIRST : addr + 1'b1;
        end
      end
      if (data_done && wr_dir && is_fifo && !push_ready) fifo_ovf <= 1'b1;
      if (data_done && !wr_dir && is_fifo && !have_q)    fifo_udf <= 1'b1;
    end
  end

  assert_addr_skips_fifo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !is_fifo) |=> (addr != FIFO_ADDR));

  assert_pop_has_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ready |-> pop_valid);

  assert_udf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_udf |=> fifo_udf);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  input  logic              push_ready,
  input  logic              pop_valid,
  input  logic [DATA_W-1:0] pop_data,
  output logic              pop_ready,
  output logic              fifo_ovf,
  output logic              fifo_udf
);
  logic [2:0] pins_s;
  logic       sck_s, mosi_s, sel_s;
  logic       load_en, byte_done, cmd_byte;
  byte_t      load_byte, rx_byte;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi}), .q(pins_s)
  );

  assign sel_s  = ~pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .mosi_s(mosi_s), .sel_s(sel_s),
    .load_en(load_en), .load_byte(load_byte), .miso(spi_miso),
    .byte_done(byte_done), .cmd_byte(cmd_byte), .rx_byte(rx_byte)
  );

  spi_access u_access (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .byte_done(byte_done),
    .cmd_byte(cmd_byte), .rx_byte(rx_byte), .load_en(load_en),
    .load_byte(load_byte), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_valid(push_valid),
    .push_data(push_data), .push_ready(push_ready), .pop_valid(pop_valid),
    .pop_data(pop_data), .pop_ready(pop_ready), .fifo_ovf(fifo_ovf),
    .fifo_udf(fifo_udf)
  );
endmodule

// File: tb/tb_spi_reg_slave.sv
`timescale 1ns/1ps
module tb_spi_reg_slave;
  localparam int HALF = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic spi_miso;
  logic [6:0] reg_addr;
  logic reg_we, push_valid, pop_ready, fifo_ovf, fifo_udf;
  logic [7:0] reg_wdata, reg_rdata, push_data, pop_data;
  logic push_ready, pop_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
    .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'(a * 29 + 7);
  endfunction
  function automatic logic [7:0] new_val(int a);
    return 8'((a * 53) ^ 8'hA5);
  endfunction
  function automatic int nxt(int a);
    return (a == 127) ? 1 : a + 1;
  endfunction

  // register file model
  logic [7:0] regmem [0:127];
  assign reg_rdata = regmem[reg_addr];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < 128; i++) regmem[i] <= init_val(i);
    else if (reg_we) regmem[reg_addr] <= reg_wdata;

  // 4-entry queue model
  logic [7:0] fq [0:3];
  logic [1:0] fwr, frd;
  logic [2:0] fcnt;
  assign push_ready = (fcnt < 3'd4);
  assign pop_valid  = (fcnt != 3'd0);
  assign pop_data   = fq[frd];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fwr <= '0; frd <= '0; fcnt <= '0;
      for (int i = 0; i < 4; i++) fq[i] <= '0;
    end else begin
      if (push_valid) begin fq[fwr] <= push_data; fwr <= fwr + 1'b1; end
      if (pop_ready) frd <= frd + 1'b1;
      fcnt <= fcnt + 3'(push_valid) - 3'(pop_ready);
    end

  logic [7:0] exp_reg [0:127];
  logic [7:0] tx_buf [0:199];
  logic [7:0] rx_buf [0:199];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = tx[i];
      #(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic run_frame(input int n);
    logic [7:0] r;
    spi_cs_n = 1'b0;
    #(HALF);
    for (int k = 0; k < n; k++) begin
      xfer_bits(tx_buf[k], 8, r);
      rx_buf[k] = r;
    end
    #(HALF);
    spi_cs_n = 1'b1;
    #(4*HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int a;
    for (int i = 0; i < 128; i++) exp_reg[i] = init_val(i);
    #80;
    // R9 reset state
    check("R9 miso", spi_miso, 0);
    check("R9 ovf", fifo_ovf, 0);
    check("R9 udf", fifo_udf, 0);
    check("R9 strobes", {reg_we, push_valid, pop_ready}, 0);
    rst_n = 1'b1;
    #(4*HALF);

    // R1 R5: single-byte writes over every register address
    for (int ad = 1; ad < 128; ad++) begin
      tx_buf[0] = 8'h80 | 8'(ad);
      tx_buf[1] = new_val(ad);
      run_frame(2);
      check("R6 miso zero in command", rx_buf[0], 0);
      check("R5 prior value on write", rx_buf[1], exp_reg[ad]);
      exp_reg[ad] = new_val(ad);
      check("R1 register written", regmem[ad], exp_reg[ad]);
    end

    // R2 R3: full burst read from 0x01, MOSI held at 0xFF
    tx_buf[0] = 8'h01;
    for (int k = 1; k < 128; k++) tx_buf[k] = 8'hFF;
    run_frame(128);
    for (int k = 1; k < 128; k++) check("R2 R3 burst read", rx_buf[k], exp_reg[k]);
    for (int k = 1; k < 128; k++) check("R1 read leaves register", regmem[k], exp_reg[k]);

    // R3 wrap on read
    tx_buf[0] = 8'h7E;
    run_frame(5);
    a = 126;
    for (int k = 1; k < 5; k++) begin
      check("R3 wrap read", rx_buf[k], exp_reg[a]);
      a = nxt(a);
    end

    // R3 R5 wrap on write
    tx_buf[0] = 8'h80 | 8'h7D;
    for (int k = 1; k < 6; k++) tx_buf[k] = 8'h30 + 8'(k);
    run_frame(6);
    a = 125;
    for (int k = 1; k < 6; k++) begin
      check("R5 burst prior value", rx_buf[k], exp_reg[a]);
      exp_reg[a] = tx_buf[k];
      check("R3 wrap write", regmem[a], exp_reg[a]);
      a = nxt(a);
    end
    check("R3 queue untouched by wrap", fcnt, 0);

    // R4 R5: fill queue
    tx_buf[0] = 8'h80;
    for (int k = 1; k < 5; k++) tx_buf[k] = 8'hC0 + 8'(k - 1);
    run_frame(5);
    for (int k = 1; k < 5; k++) check("R5 queue write returns zero", rx_buf[k], 0);
    check("R4 queue filled", fcnt, 4);
    check("R8 no overflow yet", fifo_ovf, 0);

    // R8 overflow
    tx_buf[0] = 8'h80; tx_buf[1] = 8'hEE;
    run_frame(2);
    check("R8 overflow set", fifo_ovf, 1);
    check("R8 dropped byte", fcnt, 4);

    // R4 pops across frames
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h00;
    run_frame(2);
    check("R4 first pop", rx_buf[1], 8'hC0);
    check("R4 one pop per byte", fcnt, 3);
    tx_buf[2] = 8'h00;
    run_frame(3);
    check("R4 pop order", rx_buf[1], 8'hC1);
    check("R4 pop order", rx_buf[2], 8'hC2);
    check("R7 no underflow yet", fifo_udf, 0);

    // R7 underflow
    tx_buf[3] = 8'h00;
    run_frame(4);
    check("R4 last entry", rx_buf[1], 8'hC3);
    check("R7 empty returns zero", rx_buf[2], 0);
    check("R7 empty returns zero", rx_buf[3], 0);
    check("R7 underflow set", fifo_udf, 1);
    check("R7 queue empty", fcnt, 0);
    check("R8 overflow sticky", fifo_ovf, 1);

    // R6 aborted partial byte
    spi_cs_n = 1'b0;
    #(HALF);
    xfer_bits(8'h90, 8, r);
    xfer_bits(8'h5A, 4, r);
    #(HALF);
    spi_cs_n = 1'b1;
    #(4*HALF);
    check("R6 partial byte discarded", regmem[16], exp_reg[16]);
    tx_buf[0] = 8'h10; tx_buf[1] = 8'h00;
    run_frame(2);
    check("R6 new frame starts with command", rx_buf[1], exp_reg[16]);
    check("R6 deselected miso", spi_miso, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule